// File: doc/BRIEF.md
# Dual-Pool Physical Register Free List

This block keeps the set of unallocated physical registers for a renaming core. Integer and floating-point registers share one index space: integer registers take indices `0 .. NUM_PHYS_INT-1`, and floating-point registers follow at `NUM_PHYS_INT .. NUM_PHYS_INT+NUM_PHYS_FP-1`. Each class has its own first-in first-out pool. An allocation request pops the oldest free index of its class. Freed indices come back through one of three ports:

- a range-routed port that sorts each index into the correct pool, filters out the two hardwired zero registers and drops indices outside the physical range;
- two dedicated ports that push into one pool with no checking at all.

Each pool has a small occupancy state machine, registered in one process and decoded into outputs in another. Its states are `POOL_EMPTY`, `POOL_PARTIAL` and `POOL_FULL`. The transitions are:

- `fill` (EMPTY to PARTIAL/FULL)
- `drain` (PARTIAL to EMPTY)
- `top_up` (PARTIAL to FULL)
- `spill` (FULL to PARTIAL/EMPTY)
- `hold` (no change)

The next state is chosen from the next free count. Allocating from `POOL_EMPTY` and pushing into `POOL_FULL` both set sticky error bits. Reset preloads each pool with the indices that are not initially bound to logical registers.

Top module: `reg_free_list`

## Requirements
- R1: After reset, the integer pool holds `NUM_LOG_INT .. NUM_PHYS_INT-1` in ascending order, skipping `ZERO_REG`. The FP pool holds `NUM_PHYS_INT+NUM_LOG_FP .. NUM_PHYS_INT+NUM_PHYS_FP-1` in ascending order, skipping `ZERO_REG+NUM_PHYS_INT`. Both error vectors are zero.
- R2: `alloc_int_idx` and `alloc_fp_idx` show the oldest entry of their pool whenever it is non-empty. An accepted request removes that entry at the clock edge.
- R3: On the routed port, an index below `NUM_PHYS_INT` goes to the integer pool. An index from `NUM_PHYS_INT` up to the total register count goes to the FP pool.
- R4: On the routed port, an index at or above the total register count changes neither pool.
- R5: On the routed port, index `ZERO_REG` is never added to the integer pool, and index `ZERO_REG+NUM_PHYS_INT` is never added to the FP pool.
- R6: The dedicated ports push any index, including zero registers and out-of-range values, into their own pool.
- R7: `*_has_free` is high exactly when the pool is non-empty. `*_free_cnt` equals the number of entries held, and it never exceeds that pool's physical register count.
- R8: A request to an empty pool removes nothing. It sets the sticky bit `underflow_err[0]` for the integer pool or `underflow_err[1]` for the FP pool.
- R9: An accepted allocation and a release to the same pool in one cycle both take effect, so the count stays unchanged. A release into an empty pool does not serve a same-cycle request.
- R10: A push that finds no room is dropped and sets `overflow_err[0]` (integer) or `overflow_err[1]` (FP). Room is the free space plus one slot if a pop from that pool succeeds in the same cycle.
- R11: When the routed and dedicated ports push into one pool in the same cycle, the routed index is queued ahead of the dedicated one.
- R12: Error bits stay set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset, preloads pools |
| alloc_int_req | input | 1 | Pop one integer index |
| alloc_int_idx | output | IDX_W | Oldest free integer index |
| alloc_fp_req | input | 1 | Pop one FP index |
| alloc_fp_idx | output | IDX_W | Oldest free FP index |
| rel_vld | input | 1 | Range-routed release valid |
| rel_idx | input | IDX_W | Range-routed release index |
| rel_int_vld | input | 1 | Dedicated integer release valid |
| rel_int_idx | input | IDX_W | Dedicated integer release index |
| rel_fp_vld | input | 1 | Dedicated FP release valid |
| rel_fp_idx | input | IDX_W | Dedicated FP release index |
| int_has_free | output | 1 | Integer pool non-empty |
| int_free_cnt | output | INT_CW | Integer pool occupancy |
| fp_has_free | output | 1 | FP pool non-empty |
| fp_free_cnt | output | FP_CW | FP pool occupancy |
| underflow_err | output | 2 | Sticky empty-allocation errors, bit0 integer, bit1 FP |
| overflow_err | output | 2 | Sticky full-push errors, bit0 integer, bit1 FP |

## Verification
The bench goes after the range boundaries of the routed port: the last integer index, the first FP index, the total count, and both zero registers. A design with an off-by-one comparison would file a boundary index into the wrong pool or keep an index it should drop. A directed drain of the integer pool ends in a request with a same-cycle release. A design that bypasses the release would hand out that index and leave the count at zero instead of one. Filling the FP pool past its depth, and pushing into a full pool while popping, shows whether overflow is detected with the pop's freed slot counted. Dual pushes in one cycle show whether the routed index is queued first, and random traffic compares the head order against a queue model.

// File: rtl/fl_pkg.sv
package fl_pkg;
    typedef enum logic [1:0] {
        POOL_EMPTY   = 2'd0,
        POOL_PARTIAL = 2'd1,
        POOL_FULL    = 2'd2
    } pool_state_e;
endpackage

// File: rtl/fl_rel_router.sv
module fl_rel_router #(
    parameter int NUM_PHYS_INT = 16,
    parameter int NUM_PHYS_FP  = 16,
    parameter int ZERO_REG     = 0,
    parameter int IDX_W        = 6
) (
    input  logic             vld,
    input  logic [IDX_W-1:0] idx,
    output logic             to_int,
    output logic             to_fp
);
    localparam int TOTAL = NUM_PHYS_INT + NUM_PHYS_FP;
    localparam logic [IDX_W-1:0] INT_END = IDX_W'(NUM_PHYS_INT);
    localparam logic [IDX_W-1:0] ALL_END = IDX_W'(TOTAL);
    localparam logic [IDX_W-1:0] ZI      = IDX_W'(ZERO_REG);
    localparam logic [IDX_W-1:0] ZF      = IDX_W'(ZERO_REG + NUM_PHYS_INT);

    logic in_int, in_fp;

    always_comb begin
        in_int = (idx < INT_END);
        in_fp  = (idx >= INT_END) && (idx < ALL_END);
        to_int = vld && in_int && (idx != ZI);
        to_fp  = vld && in_fp && (idx != ZF);
    end
endmodule

// File: rtl/fl_err_latch.sv
module fl_err_latch #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    output logic [N-1:0] flags
);
    always_ff @(posedge clk) begin
        if (!rst_n) flags <= '0;
        else        flags <= flags | set;
    end
endmodule

// File: rtl/fl_pool.sv
module fl_pool
    import fl_pkg::*;
#(
    parameter int DEPTH     = 16,
    parameter int IDX_W     = 6,
    parameter int PRE_FIRST = 8,
    parameter int PRE_END   = 16,
    parameter int PRE_SKIP  = 0,
    localparam int CNT_W    = $clog2(DEPTH + 1),
    localparam int PTR_W    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pop_req,
    input  logic             push_a_vld,
    input  logic [IDX_W-1:0] push_a_idx,
    input  logic             push_b_vld,
    input  logic [IDX_W-1:0] push_b_idx,
    output logic [IDX_W-1:0] head_idx,
    output logic             has_free,
    output logic [CNT_W-1:0] free_cnt,
    output logic             pop_fail,
    output logic             push_drop
);
    function automatic int pre_count();
        int n = 0;
        for (int v = PRE_FIRST; v < PRE_END; v++)
            if (v != PRE_SKIP) n++;
        return n;
    endfunction

    function automatic int pre_value(int k);
        int n = 0;
        for (int v = PRE_FIRST; v < PRE_END; v++) begin
            if (v != PRE_SKIP) begin
                if (n == k) return v;
                n++;
            end
        end
        return 0;
    endfunction

    localparam int PRE_N = pre_count();
    localparam pool_state_e RST_STATE = (PRE_N == 0)     ? POOL_EMPTY :
                                        (PRE_N == DEPTH) ? POOL_FULL  : POOL_PARTIAL;

    function automatic logic [PTR_W-1:0] ptr_inc(logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    logic [IDX_W-1:0] preload_tab [DEPTH];
    logic [IDX_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0] rd_ptr, wr_ptr, wr_ptr_b;
    logic [CNT_W-1:0] count, cnt_nxt;
    pool_state_e      state, state_nxt;

    logic pop_ok, acc_a, acc_b;
    int   room, room_b;

    for (genvar g = 0; g < DEPTH; g++) begin : g_pre
        assign preload_tab[g] = (g < PRE_N) ? IDX_W'(pre_value(g)) : '0;
    end

    // Acceptance of pops and pushes for this cycle.
    always_comb begin
        pop_ok    = pop_req && (state != POOL_EMPTY);
        pop_fail  = pop_req && (state == POOL_EMPTY);
        room      = DEPTH - int'(count) + (pop_ok ? 1 : 0);
        acc_a     = push_a_vld && (room > 0);
        room_b    = room - (acc_a ? 1 : 0);
        acc_b     = push_b_vld && (room_b > 0);
        push_drop = (push_a_vld && !acc_a) || (push_b_vld && !acc_b);
        cnt_nxt   = CNT_W'(int'(count) - (pop_ok ? 1 : 0) + (acc_a ? 1 : 0) + (acc_b ? 1 : 0));
        wr_ptr_b  = acc_a ? ptr_inc(wr_ptr) : wr_ptr;
    end

    // Occupancy state transitions.
    always_comb begin
        state_nxt = state;
        unique case (state)
            POOL_EMPTY: begin
                if (cnt_nxt == CNT_W'(DEPTH))   state_nxt = POOL_FULL;
                else if (cnt_nxt != '0)         state_nxt = POOL_PARTIAL;
            end
            POOL_PARTIAL: begin
                if (cnt_nxt == '0)              state_nxt = POOL_EMPTY;
                else if (cnt_nxt == CNT_W'(DEPTH)) state_nxt = POOL_FULL;
            end
            POOL_FULL: begin
                if (cnt_nxt == '0)              state_nxt = POOL_EMPTY;
                else if (cnt_nxt != CNT_W'(DEPTH)) state_nxt = POOL_PARTIAL;
            end
            default: state_nxt = POOL_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= RST_STATE;
        else        state <= state_nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= preload_tab[i];
            rd_ptr <= '0;
            wr_ptr <= PTR_W'(PRE_N % DEPTH);
            count  <= CNT_W'(PRE_N);
        end else begin
            if (acc_a) mem[wr_ptr]   <= push_a_idx;
            if (acc_b) mem[wr_ptr_b] <= push_b_idx;
            if (pop_ok) rd_ptr <= ptr_inc(rd_ptr);
            wr_ptr <= acc_b ? ptr_inc(wr_ptr_b) : wr_ptr_b;
            count  <= cnt_nxt;
        end
    end

    // Outputs decoded from the state register.
    always_comb begin
        has_free = (state != POOL_EMPTY);
        head_idx = mem[rd_ptr];
        free_cnt = count;
    end
endmodule

// File: rtl/reg_free_list.sv
module reg_free_list #(
    parameter int  NUM_LOG_INT  = 8,
    parameter int  NUM_PHYS_INT = 16,
    parameter int  NUM_LOG_FP   = 8,
    parameter int  NUM_PHYS_FP  = 16,
    parameter int  ZERO_REG     = 0,
    localparam int TOTAL  = NUM_PHYS_INT + NUM_PHYS_FP,
    localparam int IDX_W  = $clog2(TOTAL) + 1,
    localparam int INT_CW = $clog2(NUM_PHYS_INT + 1),
    localparam int FP_CW  = $clog2(NUM_PHYS_FP + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_int_req,
    output logic [IDX_W-1:0]  alloc_int_idx,
    input  logic              alloc_fp_req,
    output logic [IDX_W-1:0]  alloc_fp_idx,
    input  logic              rel_vld,
    input  logic [IDX_W-1:0]  rel_idx,
    input  logic              rel_int_vld,
    input  logic [IDX_W-1:0]  rel_int_idx,
    input  logic              rel_fp_vld,
    input  logic [IDX_W-1:0]  rel_fp_idx,
    output logic              int_has_free,
    output logic [INT_CW-1:0] int_free_cnt,
    output logic              fp_has_free,
    output logic [FP_CW-1:0]  fp_free_cnt,
    output logic [1:0]        underflow_err,
    output logic [1:0]        overflow_err
);
    logic route_int, route_fp;
    logic [1:0] pop_fail, push_drop;

    fl_rel_router #(
        .NUM_PHYS_INT(NUM_PHYS_INT), .NUM_PHYS_FP(NUM_PHYS_FP),
        .ZERO_REG(ZERO_REG), .IDX_W(IDX_W)
    ) u_router (
        .vld(rel_vld), .idx(rel_idx), .to_int(route_int), .to_fp(route_fp)
    );

    fl_pool #(
        .DEPTH(NUM_PHYS_INT), .IDX_W(IDX_W),
        .PRE_FIRST(NUM_LOG_INT), .PRE_END(NUM_PHYS_INT), .PRE_SKIP(ZERO_REG)
    ) u_int_pool (
        .clk(clk), .rst_n(rst_n), .pop_req(alloc_int_req),
        .push_a_vld(route_int), .push_a_idx(rel_idx),
        .push_b_vld(rel_int_vld), .push_b_idx(rel_int_idx),
        .head_idx(alloc_int_idx), .has_free(int_has_free), .free_cnt(int_free_cnt),
        .pop_fail(pop_fail[0]), .push_drop(push_drop[0])
    );

    fl_pool #(
        .DEPTH(NUM_PHYS_FP), .IDX_W(IDX_W),
        .PRE_FIRST(NUM_PHYS_INT + NUM_LOG_FP), .PRE_END(TOTAL),
        .PRE_SKIP(ZERO_REG + NUM_PHYS_INT)
    ) u_fp_pool (
        .clk(clk), .rst_n(rst_n), .pop_req(alloc_fp_req),
        .push_a_vld(route_fp), .push_a_idx(rel_idx),
        .push_b_vld(rel_fp_vld), .push_b_idx(rel_fp_idx),
        .head_idx(alloc_fp_idx), .has_free(fp_has_free), .free_cnt(fp_free_cnt),
        .pop_fail(pop_fail[1]), .push_drop(push_drop[1])
    );

    fl_err_latch #(.N(2)) u_uf (.clk(clk), .rst_n(rst_n), .set(pop_fail),  .flags(underflow_err));
    fl_err_latch #(.N(2)) u_of (.clk(clk), .rst_n(rst_n), .set(push_drop), .flags(overflow_err));
endmodule

// File: rtl/fl_free_list_checks.sv
module fl_free_list_checks #(
    parameter int NPI    = 16,
    parameter int NPF    = 16,
    parameter int ZR     = 0,
    parameter int IDX_W  = 6,
    parameter int INT_CW = 5,
    parameter int FP_CW  = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              alloc_int_req,
    input logic              alloc_fp_req,
    input logic              rel_vld,
    input logic [IDX_W-1:0]  rel_idx,
    input logic              rel_int_vld,
    input logic              rel_fp_vld,
    input logic              int_has_free,
    input logic [INT_CW-1:0] int_free_cnt,
    input logic              fp_has_free,
    input logic [FP_CW-1:0]  fp_free_cnt,
    input logic [1:0]        underflow_err,
    input logic [1:0]        overflow_err
);
    p_int_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        int_has_free == (int_free_cnt != '0));
    p_fp_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        int'(fp_free_cnt) <= NPF && int'(int_free_cnt) <= NPI);
    p_uf_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_int_req && !int_has_free |=> underflow_err[0]);
    p_uf_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
        underflow_err[1] |=> underflow_err[1]);
    p_of_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
        overflow_err[0] |=> overflow_err[0]);
    p_discard_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rel_vld && int'(rel_idx) >= NPI + NPF && !alloc_int_req && !rel_int_vld
        && !alloc_fp_req && !rel_fp_vld |=> $stable(int_free_cnt) && $stable(fp_free_cnt));
    p_zero_filter_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rel_vld && int'(rel_idx) == ZR && !alloc_int_req && !rel_int_vld
        |=> $stable(int_free_cnt));
    p_same_cycle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_fp_req && fp_has_free && rel_fp_vld && !rel_vld |=> $stable(fp_free_cnt));
    p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rel_fp_vld && int'(fp_free_cnt) == NPF && !alloc_fp_req && !rel_vld
        |=> overflow_err[1] && int'(fp_free_cnt) == NPF);
endmodule

bind reg_free_list fl_free_list_checks #(
    .NPI(NUM_PHYS_INT), .NPF(NUM_PHYS_FP), .ZR(ZERO_REG),
    .IDX_W(IDX_W), .INT_CW(INT_CW), .FP_CW(FP_CW)
) u_checks (
    .clk(clk), .rst_n(rst_n), .alloc_int_req(alloc_int_req), .alloc_fp_req(alloc_fp_req),
    .rel_vld(rel_vld), .rel_idx(rel_idx), .rel_int_vld(rel_int_vld), .rel_fp_vld(rel_fp_vld),
    .int_has_free(int_has_free), .int_free_cnt(int_free_cnt),
    .fp_has_free(fp_has_free), .fp_free_cnt(fp_free_cnt),
    .underflow_err(underflow_err), .overflow_err(overflow_err)
);

// File: tb/reg_free_list_test.sv
module reg_free_list_test;
    localparam int NLI = 8, NPI = 16, NLF = 8, NPF = 16, ZR = 0;
    localparam int TOT = NPI + NPF;
    localparam int IW  = $clog2(TOT) + 1;
    localparam int ICW = $clog2(NPI + 1);
    localparam int FCW = $clog2(NPF + 1);

    logic clk = 1'b0;
    logic rst_n;
    logic a_int, a_fp, rv, riv, rfv;
    logic [IW-1:0] ri, rii, rfi;
    logic [IW-1:0] o_int_idx, o_fp_idx;
    logic o_int_hf, o_fp_hf;
    logic [ICW-1:0] o_int_cnt;
    logic [FCW-1:0] o_fp_cnt;
    logic [1:0] o_uf, o_of;

    int checks = 0, errors = 0;
    int qi[$], qf[$];
    bit [1:0] m_uf, m_of;

    always #2 clk = ~clk;

    reg_free_list #(.NUM_LOG_INT(NLI), .NUM_PHYS_INT(NPI), .NUM_LOG_FP(NLF),
                    .NUM_PHYS_FP(NPF), .ZERO_REG(ZR)) uut (
        .clk(clk), .rst_n(rst_n),
        .alloc_int_req(a_int), .alloc_int_idx(o_int_idx),
        .alloc_fp_req(a_fp), .alloc_fp_idx(o_fp_idx),
        .rel_vld(rv), .rel_idx(ri), .rel_int_vld(riv), .rel_int_idx(rii),
        .rel_fp_vld(rfv), .rel_fp_idx(rfi),
        .int_has_free(o_int_hf), .int_free_cnt(o_int_cnt),
        .fp_has_free(o_fp_hf), .fp_free_cnt(o_fp_cnt),
        .underflow_err(o_uf), .overflow_err(o_of)
    );

    task automatic chk(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic bit route_int(int idx);
        return idx < NPI && idx != ZR;
    endfunction
    function automatic bit route_fp(int idx);
        return idx >= NPI && idx < TOT && idx != ZR + NPI;
    endfunction

    task automatic check_all(string tag);
        chk(tag, "int_cnt", int'(o_int_cnt), qi.size());
        chk(tag, "fp_cnt", int'(o_fp_cnt), qf.size());
        chk(tag, "int_has_free", int'(o_int_hf), int'(qi.size() != 0));
        chk(tag, "fp_has_free", int'(o_fp_hf), int'(qf.size() != 0));
        chk(tag, "underflow", int'(o_uf), int'(m_uf));
        chk(tag, "overflow", int'(o_of), int'(m_of));
        if (qi.size() != 0) chk(tag, "int_head", int'(o_int_idx), qi[0]);
        if (qf.size() != 0) chk(tag, "fp_head", int'(o_fp_idx), qf[0]);
    endtask

    task automatic model_push(int pool, int idx, ref int room);
        if (room > 0) begin
            room--;
            if (pool == 0) qi.push_back(idx); else qf.push_back(idx);
        end else m_of[pool] = 1'b1;
    endtask

    // One clock cycle of stimulus starting at a falling edge.
    task automatic cyc(string tag, bit ai, bit af, bit g, int gi, bit di, int dii, bit df, int dfi);
        int room_i, room_f;
        bit pi, pf;
        a_int = ai; a_fp = af; rv = g; ri = IW'(gi);
        riv = di; rii = IW'(dii); rfv = df; rfi = IW'(dfi);
        pi = ai && qi.size() != 0;
        pf = af && qf.size() != 0;
        if (ai && !pi) m_uf[0] = 1'b1;
        if (af && !pf) m_uf[1] = 1'b1;
        room_i = NPI - qi.size() + int'(pi);
        room_f = NPF - qf.size() + int'(pf);
        if (pi) void'(qi.pop_front());
        if (pf) void'(qf.pop_front());
        if (g && route_int(gi)) model_push(0, gi, room_i);
        if (g && route_fp(gi))  model_push(1, gi, room_f);
        if (di) model_push(0, dii, room_i);
        if (df) model_push(1, dfi, room_f);
        @(posedge clk);
        @(negedge clk);
        a_int = 0; a_fp = 0; rv = 0; riv = 0; rfv = 0;
        check_all(tag);
    endtask

    task automatic do_reset();
        rst_n = 0; a_int = 0; a_fp = 0; rv = 0; riv = 0; rfv = 0;
        ri = '0; rii = '0; rfi = '0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        qi.delete(); qf.delete(); m_uf = '0; m_of = '0;
        for (int v = NLI; v < NPI; v++) if (v != ZR) qi.push_back(v);
        for (int v = NPI + NLF; v < TOT; v++) if (v != ZR + NPI) qf.push_back(v);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        do_reset();
        check_all("R1");
        // R2: FIFO order
        for (int k = 0; k < 3; k++) cyc("R2", 1, 0, 0, 0, 0, 0, 0, 0);
        cyc("R2", 0, 1, 0, 0, 0, 0, 0, 0);
        // R3: range boundaries on the routed port
        cyc("R3", 0, 0, 1, NPI - 1, 0, 0, 0, 0);
        cyc("R3", 0, 0, 1, NPI, 0, 0, 0, 0);
        cyc("R3", 0, 0, 1, TOT - 1, 0, 0, 0, 0);
        // R4: beyond the physical range
        cyc("R4", 0, 0, 1, TOT, 0, 0, 0, 0);
        cyc("R4", 0, 0, 1, (1 << IW) - 1, 0, 0, 0, 0);
        // R5: zero registers filtered
        cyc("R5", 0, 0, 1, ZR, 0, 0, 0, 0);
        cyc("R5", 0, 0, 1, ZR + NPI, 0, 0, 0, 0);
        // R6: dedicated ports unfiltered
        cyc("R6", 0, 0, 0, 0, 1, ZR, 1, ZR + NPI);
        cyc("R6", 0, 0, 0, 0, 1, TOT + 3, 1, 2);
        // R11: routed before dedicated, same pool
        cyc("R11", 0, 0, 1, 5, 1, 7, 0, 0);
        cyc("R11", 0, 0, 1, 20, 0, 0, 1, 22);
        // R9: alloc with release, non-empty pool
        cyc("R9", 1, 0, 0, 0, 1, 11, 0, 0);
        cyc("R9", 0, 1, 1, 19, 0, 0, 0, 0);
        // R8: drain integer pool, then empty alloc with release (no bypass)
        while (qi.size() != 0) cyc("R2", 1, 0, 0, 0, 0, 0, 0, 0);
        cyc("R8", 1, 0, 0, 0, 1, 12, 0, 0);
        chk("R9", "int_cnt_no_bypass", int'(o_int_cnt), 1);
        cyc("R8", 1, 0, 0, 0, 0, 0, 0, 0);
        cyc("R8", 1, 0, 0, 0, 0, 0, 0, 0);
        // R10: fill FP pool and overflow
        while (qf.size() < NPF) cyc("R10", 0, 0, 0, 0, 0, 0, 1, 40);
        cyc("R10", 0, 0, 0, 0, 0, 0, 1, 41);
        chk("R10", "fp_full", int'(o_fp_cnt), NPF);
        cyc("R10", 0, 1, 0, 0, 0, 0, 1, 42);
        cyc("R10", 0, 1, 1, NPI + 2, 0, 0, 1, 43);
        cyc("R12", 0, 0, 0, 0, 0, 0, 0, 0);
        chk("R12", "sticky_uf_int", int'(o_uf[0]), 1);
        // R12: reset clears errors
        do_reset();
        check_all("R12");
        chk("R12", "uf_cleared", int'(o_uf), 0);
        // Random traffic
        for (int n = 0; n < 4000; n++) begin
            bit ai, af, g, di, df;
            ai = ($urandom % 3) == 0;
            af = ($urandom % 3) == 0;
            g  = ($urandom % 2) == 0;
            di = ($urandom % 6) == 0;
            df = ($urandom % 6) == 0;
            cyc("R2/R3/R7", ai, af, g, int'($urandom % (1 << IW)), di,
                int'($urandom % (1 << IW)), df, int'($urandom % (1 << IW)));
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule